// File: doc/BRIEF.md
# Sectioned Carry-Skip Adder

This block adds two unsigned binary words and a carry-in and produces the sum and the carry-out. It is purely combinational, with no clock and no reset. The operand width is split into equal sections. Inside a section, the carry ripples from bit to bit through a generate/propagate step.

Each section also has a bypass. When every bit of the section propagates, the incoming carry goes straight to the section's outgoing carry and does not wait for the ripple. The outgoing carry of every section comes from a three-way select whose controls are one-hot, so no two sources ever drive it together:

- the section carry-in, when all bits propagate;
- the rippled carry into the top bit, when the top bit propagates but a lower bit does not;
- the top bit's own generate, when the top bit does not propagate.

Wide adders use the block where a ripple chain is too slow and a full lookahead tree costs too much area.

Top module: `carry_skip_adder`

## Requirements
- R1: For every input, {carry_out, sum_out} equals opnd_a + opnd_b + carry_in, evaluated as unsigned numbers `WIDTH`+1 bits wide. The outputs follow the inputs with no clock.
- R2: Each bit falls into exactly one class. It generates when both operand bits are 1, kills when both are 0, and propagates when they differ.
- R3: When every bit of a section propagates, that section's carry-out equals its carry-in. For example, with opnd_a XOR opnd_b all ones, sum_out is all ones for carry_in=0 and all zeros for carry_in=1, and carry_out equals carry_in.
- R4: Exactly one of a section's three carry selects (bypass, ripple, top-bit) is active for every input.
- R5: When the top bit of a section does not propagate, the section carry-out is 1 if that bit generates and 0 if it kills, whatever the lower bits and the carry-in are.
- R6: When the top bit of a section propagates and some lower bit does not, the section carry-out equals the carry rippled into the top bit.
- R7: Sum bit i equals the propagate of bit i XOR the carry into bit i. The carry into the next bit within a section is the generate of bit i, OR the propagate of bit i AND the carry into bit i.
- R8: `WIDTH` and `SECTION` are parameters, and `WIDTH` must be a whole multiple of `SECTION`. R1 holds for any such pair, including sections of odd size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First addend |
| opnd_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the last section |

## Verification
The bench builds two copies of the adder. The first uses the defaults (16 bits, four sections of 4), so carries cross three bypass stages and every section can be steered into bypass, ripple or top-bit mode on its own. The second uses 9 bits in sections of 3, which checks that the select logic and the lower-bit propagate test scale to odd section sizes. On the 3-bit sections, a carry chain that spans all three sections is short enough to set up by hand.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // carry into the next bit of a section
  function automatic logic carry_step(input logic gen, input logic prop, input logic cin);
    return gen | (prop & cin);
  endfunction

  // sum bit from the half-sum and the incoming carry
  function automatic logic sum_bit(input logic prop, input logic cin);
    return prop ^ cin;
  endfunction
endpackage

// File: rtl/csa_bit_class.sv
module csa_bit_class (
  input  logic a,
  input  logic b,
  output logic gen,
  output logic kill,
  output logic prop
);
  assign gen  = a & b;
  assign kill = ~a & ~b;
  assign prop = a ^ b;

  always_comb begin
    assert_one_class_R2: assert ($onehot({gen, kill, prop}))
      else $error("bit in more or fewer than one class");
  end
endmodule

// File: rtl/csa_section.sv
module csa_section #(
  parameter int M = 4
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic         cin,
  output logic [M-1:0] sum,
  output logic         cout
);
  logic [M-1:0] gen, kill, prop;
  logic [M-1:0] chain;        // carry into each bit
  logic         lower_all;    // every bit below the top propagates
  logic         sel_bypass, sel_ripple, sel_top;

  for (genvar i = 0; i < M; i++) begin : g_bit
    csa_bit_class u_cls (
      .a(a[i]), .b(b[i]),
      .gen(gen[i]), .kill(kill[i]), .prop(prop[i])
    );
  end

  always_comb begin
    chain[0] = cin;
    for (int i = 0; i < M - 1; i++)
      chain[i+1] = csa_pkg::carry_step(gen[i], prop[i], chain[i]);
  end

  if (M > 1) begin : g_lower
    assign lower_all = &prop[M-2:0];
  end else begin : g_single
    assign lower_all = 1'b1;
  end

  assign sel_bypass = lower_all & prop[M-1];
  assign sel_ripple = ~lower_all & prop[M-1];
  assign sel_top    = ~prop[M-1];

  // one-hot AND-OR select: never two sources at once
  assign cout = (sel_bypass & cin) | (sel_ripple & chain[M-1]) | (sel_top & gen[M-1]);

  always_comb begin
    for (int i = 0; i < M; i++)
      sum[i] = csa_pkg::sum_bit(prop[i], chain[i]);
  end

  always_comb begin
    assert_sel_onehot_R4: assert ($onehot({sel_bypass, sel_ripple, sel_top}))
      else $error("section carry select not one-hot");
    assert_bypass_carry_R3: assert (!sel_bypass || (cout == cin))
      else $error("bypass did not pass carry-in");
    assert_top_kill_R5: assert (!(sel_top && kill[M-1] && cout))
      else $error("killed top bit yet carry-out high");
    assert_section_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (M+1)'(cin)))
      else $error("section result differs from arithmetic");
  end
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int WIDTH   = 16,
  parameter int SECTION = 4
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int NSEC = WIDTH / SECTION;

  if ((WIDTH % SECTION) != 0 || SECTION < 1) begin : g_bad_split
    $error("WIDTH must be a positive multiple of SECTION");
  end

  logic [NSEC:0] sec_carry;   // carry between sections

  assign sec_carry[0] = carry_in;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    csa_section #(.M(SECTION)) u_sec (
      .a   (opnd_a[s*SECTION +: SECTION]),
      .b   (opnd_b[s*SECTION +: SECTION]),
      .cin (sec_carry[s]),
      .sum (sum_out[s*SECTION +: SECTION]),
      .cout(sec_carry[s+1])
    );
  end

  assign carry_out = sec_carry[NSEC];

  always_comb begin
    assert_total_sum_R1: assert ({carry_out, sum_out} ==
        ({1'b0, opnd_a} + {1'b0, opnd_b} + (WIDTH+1)'(carry_in)))
      else $error("adder result differs from arithmetic");
  end
endmodule

// File: tb/carry_skip_adder_test.sv
module carry_skip_adder_test;
  localparam int W  = 16;
  localparam int W2 = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [W2-1:0] a2, b2, s2;
  logic          ci2, co2;

  int checks = 0;
  int fails  = 0;

  carry_skip_adder #(.WIDTH(W), .SECTION(4)) uut (
    .opnd_a(a), .opnd_b(b), .carry_in(ci), .sum_out(s), .carry_out(co));
  carry_skip_adder #(.WIDTH(W2), .SECTION(3)) uut_fine (
    .opnd_a(a2), .opnd_b(b2), .carry_in(ci2), .sum_out(s2), .carry_out(co2));

  // independent bit-serial model: majority carry, three-input parity sum
  function automatic logic [W:0] model16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] r;
    logic cc = c;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc   = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
    end
    r[W] = cc;
    return r;
  endfunction

  function automatic logic [W2:0] model9(input logic [W2-1:0] x, input logic [W2-1:0] y, input logic c);
    logic [W2:0] r;
    logic cc = c;
    for (int i = 0; i < W2; i++) begin
      r[i] = x[i] ^ y[i] ^ cc;
      cc   = (x[i] & y[i]) | (x[i] & cc) | (y[i] & cc);
    end
    r[W2] = cc;
    return r;
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; ci = c;
    @(negedge clk);
    check(req, {co, s}, model16(x, y, c));
  endtask

  task automatic run9(input string req, input logic [W2-1:0] x, input logic [W2-1:0] y, input logic c);
    @(posedge clk);
    a2 = x; b2 = y; ci2 = c;
    @(negedge clk);
    check(req, (W+1)'({co2, s2}), (W+1)'(model9(x, y, c)));
  endtask

  // {carry_in, a, b}: bypass / ripple / top-bit patterns per section
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h0001, 16'hFFFF},  // chain through every section
    {1'b0, 16'h5555, 16'hAAAA},  // all propagate, cin 0
    {1'b1, 16'h5555, 16'hAAAA},  // all propagate, cin 1
    {1'b0, 16'h0000, 16'h0000},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h0F0F, 16'hF0F0},
    {1'b1, 16'hF00F, 16'h0FF0},
    {1'b1, 16'h0880, 16'h0780},
    {1'b0, 16'h8888, 16'h8888},
    {1'b1, 16'h7777, 16'h0000},
    {1'b0, 16'h1248, 16'h0FF7},
    {1'b1, 16'hABCD, 16'h5432}
  };

  initial begin
    a = '0; b = '0; ci = 1'b0;
    a2 = '0; b2 = '0; ci2 = 1'b0;
    @(negedge clk);
    check("R1 idle zero", {co, s}, '0);

    for (int i = 0; i < NV; i++)
      run16("R1 table", VEC[i][31:16], VEC[i][15:0], VEC[i][32]);

    // R3: every section bypasses, result = ~cin fill, carry_out = cin
    run16("R3 bypass cin0", 16'h33CC, 16'hCC33, 1'b0);
    check("R3 bypass cin0 value", {co, s}, {1'b0, 16'hFFFF});
    run16("R3 bypass cin1", 16'h33CC, 16'hCC33, 1'b1);
    check("R3 bypass cin1 value", {co, s}, {1'b1, 16'h0000});

    // R5: top bit of section 0 generates, lower bits would pass cin
    run16("R5 top generate", 16'h0008, 16'h000F, 1'b0);
    check("R5 top generate value", {co, s}, {1'b0, 16'h0017});
    // R5: top bit of section 0 kills despite lower generate
    run16("R5 top kill", 16'h0007, 16'h0007, 1'b1);
    check("R5 top kill value", {co, s}, {1'b0, 16'h000F});

    // R6: top propagates, bit 0 generates, carry ripples into bit 4
    run16("R6 ripple", 16'h0009, 16'h0007, 1'b0);
    check("R6 ripple value", {co, s}, {1'b0, 16'h0010});

    // R2 / R7: each class per bit across all lanes
    run16("R2 R7 mixed classes", 16'hF0AA, 16'hFF50, 1'b0);

    for (int i = 0; i < 400; i++)
      run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));

    // R8: 9-bit build in 3-bit sections
    run9("R8 chain", 9'h001, 9'h1FF, 1'b0);
    check("R8 chain value", (W+1)'({co2, s2}), (W+1)'({1'b1, 9'h000}));
    run9("R8 bypass", 9'h0AA, 9'h155, 1'b1);
    for (int i = 0; i < 200; i++)
      run9("R8 random", 9'($urandom), 9'($urandom), 1'($urandom));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog got=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule